// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer

This block turns a digitised supply level into an active-low reset for the logic it guards. After start-up or a synchronous clear, the output stays low until the level code climbs strictly above a programmable trip level. It then stays low for a programmed number of clock ticks before it lets go.

Once released, the block watches for dips. A level at or below the trip level has to persist before it counts. A shallow dip must last the full programmed qualification count. A deep dip, one that falls below the trip level minus a hysteresis band, qualifies after a short fixed count, so a serious brown-out is caught quickly while noise near the threshold is filtered out. A qualified dip starts a complete reset period. At the end of that period the output is released only if the level is good again. Otherwise the block goes back to waiting for the level to rise.

Top module: `smr_reset_seq`

## Requirements
- R1: While in the waiting state, `rst_n_o` stays 0 for as long as `lvl_code` is less than or equal to `trip_lvl` (unsigned compare).
- R2: The first cycle in which `lvl_code > trip_lvl` is sampled starts a hold. `rst_n_o` then stays 0 for exactly `hold_ticks` further clock edges (a value of 0 acts as 1), and goes to 1 on the last of those edges if the level is still good.
- R3: While `rst_n_o` is 1, a shallow dip (`trip_lvl - hyst_band <= lvl_code <= trip_lvl`) has no effect unless it lasts `qual_ticks` consecutive sampled cycles (0 acts as 1). `rst_n_o` goes to 0 on the edge that samples the last cycle of that count.
- R4: The dip count clears on any sampled cycle with `lvl_code > trip_lvl`, so a broken dip must qualify again from zero.
- R5: A qualified dip holds `rst_n_o` at 0 for a full `hold_ticks` period, even when the level recovers at once.
- R6: At the end of a hold period, `rst_n_o` goes to 1 only if `lvl_code > trip_lvl` on that edge. Otherwise the block returns to the waiting state of R1, and a later good level starts a fresh full period.
- R7: A deep dip (`lvl_code < trip_lvl - hyst_band`, no underflow) qualifies once the dip count reaches `FAST_QUAL`, or `qual_ticks` if that is smaller. Cycles of shallow dip just before it add to the same count.
- R8: `srst` high forces `rst_n_o` to 0 on the next edge, clears all counts, and leaves the block in the waiting state.
- R9: While `rst_n_o` is 1, a sampled level above `trip_lvl` never drives `rst_n_o` low on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| lvl_code | input | CODE_W | Digitised supply level |
| trip_lvl | input | CODE_W | Trip threshold; the level is good when strictly above it |
| hyst_band | input | CODE_W | Margin below the trip level that marks a deep dip |
| hold_ticks | input | PER_W | Reset period in clock ticks |
| qual_ticks | input | QUAL_W | Qualification count for a shallow dip |
| rst_n_o | output | 1 | Active-low reset output, registered |

## Verification
The bench builds the block with 8-bit codes, an 8-bit period, a 6-bit qualification count and `FAST_QUAL` = 2. The table runs with a trip level of 100, a band of 10, a period of 5 and a qualification count of 4. These small values bring every state change within a few cycles. The bench hits the exact edge on which a hold ends, the cycle on which a shallow dip becomes long enough, the faster deep-dip path, a shallow run that turns deep, and the return to waiting when the level is still bad at the end of a period. Directed cases then apply a mid-run clear and set both the period and the qualification count to 1.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } smr_state_e;

    typedef struct packed {
        smr_state_e st;
        logic       rst_n;
    } smr_fsm_t;

endpackage

// File: rtl/smr_level_cmp.sv
module smr_level_cmp #(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] lvl_code,
    input  logic [CODE_W-1:0] trip_lvl,
    input  logic [CODE_W-1:0] hyst_band,
    output logic              good,
    output logic              deep
);
    localparam int EXT_W = CODE_W + 1;

    logic [EXT_W-1:0] lvl_plus_band;

    always_comb begin
        lvl_plus_band = {1'b0, lvl_code} + {1'b0, hyst_band};
        good          = (lvl_code > trip_lvl);
        // lvl + band < trip is lvl < trip - band without underflow
        deep          = (lvl_plus_band < {1'b0, trip_lvl});
    end
endmodule

// File: rtl/smr_dip_qual.sv
module smr_dip_qual #(
    parameter int QUAL_W    = 6,
    parameter int FAST_QUAL = 2
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              arm,
    input  logic              good,
    input  logic              deep,
    input  logic [QUAL_W-1:0] qual_ticks,
    output logic              trip
);
    localparam int QC_W = QUAL_W + 1;
    localparam logic [QC_W-1:0] QC_MAX  = {QC_W{1'b1}};
    localparam logic [QC_W-1:0] FAST_LIM = QC_W'(FAST_QUAL < 1 ? 1 : FAST_QUAL);

    typedef struct packed {
        logic [QC_W-1:0] cnt;
    } qual_reg_t;

    qual_reg_t       r_q, r_d;
    logic [QC_W-1:0] slow_lim;
    logic [QC_W-1:0] lim;
    logic [QC_W-1:0] cnt_inc;

    always_comb begin
        slow_lim = (qual_ticks == '0) ? QC_W'(1) : {1'b0, qual_ticks};
        if (deep)
            lim = (FAST_LIM < slow_lim) ? FAST_LIM : slow_lim;
        else
            lim = slow_lim;
        cnt_inc = (r_q.cnt == QC_MAX) ? QC_MAX : r_q.cnt + QC_W'(1);
        trip    = arm && !good && (cnt_inc >= lim);

        r_d = r_q;
        if (!arm || good || trip)
            r_d.cnt = '0;
        else
            r_d.cnt = cnt_inc;
    end

    always_ff @(posedge clk) begin
        if (srst)
            r_q <= '0;
        else
            r_q <= r_d;
    end
endmodule

// File: rtl/smr_period_tmr.sv
module smr_period_tmr #(
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             srst,
    input  logic             load,
    input  logic             en,
    input  logic [PER_W-1:0] hold_ticks,
    output logic             done
);
    typedef struct packed {
        logic [PER_W-1:0] cnt;
    } per_reg_t;

    per_reg_t         r_q, r_d;
    logic [PER_W-1:0] load_val;

    always_comb begin
        load_val = (hold_ticks == '0) ? PER_W'(1) : hold_ticks;
        done     = (r_q.cnt <= PER_W'(1));

        r_d = r_q;
        if (load)
            r_d.cnt = load_val;
        else if (en && !done)
            r_d.cnt = r_q.cnt - PER_W'(1);
    end

    always_ff @(posedge clk) begin
        if (srst)
            r_q <= '0;
        else
            r_q <= r_d;
    end
endmodule

// File: rtl/smr_reset_seq.sv
module smr_reset_seq #(
    parameter int CODE_W    = 8,
    parameter int PER_W     = 8,
    parameter int QUAL_W    = 6,
    parameter int FAST_QUAL = 2
) (
    input  logic              clk,
    input  logic              srst,
    input  logic [CODE_W-1:0] lvl_code,
    input  logic [CODE_W-1:0] trip_lvl,
    input  logic [CODE_W-1:0] hyst_band,
    input  logic [PER_W-1:0]  hold_ticks,
    input  logic [QUAL_W-1:0] qual_ticks,
    output logic              rst_n_o
);
    import smr_pkg::*;

    smr_fsm_t fsm_q, fsm_d;
    logic     good, deep, trip, done, load;

    smr_level_cmp #(.CODE_W(CODE_W)) u_cmp (
        .lvl_code  (lvl_code),
        .trip_lvl  (trip_lvl),
        .hyst_band (hyst_band),
        .good      (good),
        .deep      (deep)
    );

    smr_dip_qual #(.QUAL_W(QUAL_W), .FAST_QUAL(FAST_QUAL)) u_qual (
        .clk        (clk),
        .srst       (srst),
        .arm        (fsm_q.st == ST_RUN),
        .good       (good),
        .deep       (deep),
        .qual_ticks (qual_ticks),
        .trip       (trip)
    );

    smr_period_tmr #(.PER_W(PER_W)) u_per (
        .clk        (clk),
        .srst       (srst),
        .load       (load),
        .en         (fsm_q.st == ST_HOLD),
        .hold_ticks (hold_ticks),
        .done       (done)
    );

    always_comb begin
        fsm_d = fsm_q;
        load  = 1'b0;
        unique case (fsm_q.st)
            ST_WAIT: begin
                if (good) begin
                    fsm_d.st = ST_HOLD;
                    load     = 1'b1;
                end
            end
            ST_HOLD: begin
                if (done)
                    fsm_d.st = good ? ST_RUN : ST_WAIT;
            end
            ST_RUN: begin
                if (trip) begin
                    fsm_d.st = ST_HOLD;
                    load     = 1'b1;
                end
            end
            default: fsm_d.st = ST_WAIT;
        endcase
        fsm_d.rst_n = (fsm_d.st == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (srst)
            fsm_q <= '{st: ST_WAIT, rst_n: 1'b0};
        else
            fsm_q <= fsm_d;
    end

    assign rst_n_o = fsm_q.rst_n;
endmodule

// File: rtl/smr_reset_seq_chk.sv
module smr_reset_seq_chk #(
    parameter int CODE_W    = 8,
    parameter int PER_W     = 8,
    parameter int QUAL_W    = 6,
    parameter int FAST_QUAL = 2
) (
    input logic              clk,
    input logic              srst,
    input logic [CODE_W-1:0] lvl_code,
    input logic [CODE_W-1:0] trip_lvl,
    input logic [PER_W-1:0]  hold_ticks,
    input logic              rst_n_o
);
    localparam int LC_W = PER_W + 1;
    localparam int DC_W = QUAL_W + 2;
    localparam logic [LC_W-1:0] LC_MAX = {LC_W{1'b1}};
    localparam logic [DC_W-1:0] DC_MAX = {DC_W{1'b1}};
    localparam logic [DC_W-1:0] FAST_MIN = DC_W'(1);

    logic [LC_W-1:0] low_cnt;
    logic [DC_W-1:0] dip_cnt;
    logic [LC_W-1:0] per_eff;

    assign per_eff = (hold_ticks == '0) ? LC_W'(1) : {1'b0, hold_ticks};

    always_ff @(posedge clk) begin
        if (srst || rst_n_o)
            low_cnt <= '0;
        else if (low_cnt != LC_MAX)
            low_cnt <= low_cnt + LC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (srst || !rst_n_o || (lvl_code > trip_lvl))
            dip_cnt <= '0;
        else if (dip_cnt != DC_MAX)
            dip_cnt <= dip_cnt + DC_W'(1);
    end

    // R8: clear forces reset low
    p_srst_low_r8: assert property (@(posedge clk) srst |=> !rst_n_o);

    // R2: no release before a whole period of low cycles
    p_hold_len_r2: assert property (@(posedge clk) disable iff (srst)
        $rose(rst_n_o) |-> (low_cnt >= per_eff));

    // R6: release only with a good level
    p_release_good_r6: assert property (@(posedge clk) disable iff (srst)
        $rose(rst_n_o) |-> $past(lvl_code > trip_lvl));

    // R9: a good level keeps a released output released
    p_good_keeps_r9: assert property (@(posedge clk) disable iff (srst)
        (rst_n_o && (lvl_code > trip_lvl)) |=> rst_n_o);

    // R7: no trip from a dip shorter than one sample
    p_min_dip_r7: assert property (@(posedge clk) disable iff (srst)
        ($fell(rst_n_o) && !$past(srst)) |-> (dip_cnt >= FAST_MIN));
endmodule

bind smr_reset_seq smr_reset_seq_chk #(
    .CODE_W    (CODE_W),
    .PER_W     (PER_W),
    .QUAL_W    (QUAL_W),
    .FAST_QUAL (FAST_QUAL)
) u_chk (
    .clk        (clk),
    .srst       (srst),
    .lvl_code   (lvl_code),
    .trip_lvl   (trip_lvl),
    .hold_ticks (hold_ticks),
    .rst_n_o    (rst_n_o)
);

// File: tb/smr_reset_seq_tb.sv
module smr_reset_seq_tb;
    localparam int CODE_W = 8;
    localparam int PER_W  = 8;
    localparam int QUAL_W = 6;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] edges;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    // trip 100, band 10 (deep below 90), period 5, qual 4, fast 2
    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{8'd50,  8'd3, 1'b0, 4'd1}, // R1 low level waits
        '{8'd100, 8'd3, 1'b0, 4'd1}, // R1 equal is not above
        '{8'd101, 8'd1, 1'b0, 4'd2}, // R2 hold begins
        '{8'd120, 8'd4, 1'b0, 4'd2}, // R2 last low edge
        '{8'd120, 8'd1, 1'b1, 4'd2}, // R2 release
        '{8'd95,  8'd3, 1'b1, 4'd3}, // R3 short shallow dip
        '{8'd120, 8'd1, 1'b1, 4'd4}, // R4 clears count
        '{8'd95,  8'd3, 1'b1, 4'd4}, // R4 restart from zero
        '{8'd95,  8'd1, 1'b0, 4'd3}, // R3 fourth dip trips
        '{8'd120, 8'd4, 1'b0, 4'd5}, // R5 recovered yet held
        '{8'd120, 8'd1, 1'b1, 4'd5}, // R5 full period then release
        '{8'd85,  8'd1, 1'b1, 4'd7}, // R7 one deep sample
        '{8'd85,  8'd1, 1'b0, 4'd7}, // R7 second deep trips
        '{8'd85,  8'd4, 1'b0, 4'd6}, // R6 still low in period
        '{8'd85,  8'd1, 1'b0, 4'd6}, // R6 bad at end, back to wait
        '{8'd85,  8'd3, 1'b0, 4'd1}, // R1 waiting
        '{8'd130, 8'd1, 1'b0, 4'd6}, // R6 fresh period
        '{8'd130, 8'd4, 1'b0, 4'd6}, // R6 held
        '{8'd130, 8'd1, 1'b1, 4'd6}, // R6 released
        '{8'd90,  8'd1, 1'b1, 4'd3}, // R3 band edge is shallow
        '{8'd90,  8'd2, 1'b1, 4'd3}, // R3 three shallow
        '{8'd89,  8'd1, 1'b0, 4'd7}, // R7 shallow then deep
        '{8'd130, 8'd5, 1'b1, 4'd2}  // R2 period after trip
    };

    logic              clk = 1'b0;
    logic              srst;
    logic [CODE_W-1:0] lvl_code;
    logic [CODE_W-1:0] trip_lvl;
    logic [CODE_W-1:0] hyst_band;
    logic [PER_W-1:0]  hold_ticks;
    logic [QUAL_W-1:0] qual_ticks;
    logic              rst_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    smr_reset_seq #(
        .CODE_W(CODE_W), .PER_W(PER_W), .QUAL_W(QUAL_W), .FAST_QUAL(2)
    ) u_dut (
        .clk(clk), .srst(srst), .lvl_code(lvl_code), .trip_lvl(trip_lvl),
        .hyst_band(hyst_band), .hold_ticks(hold_ticks),
        .qual_ticks(qual_ticks), .rst_n_o(rst_n_o)
    );

    task automatic check(input logic exp, input int req, input string what);
        n_chk++;
        if (rst_n_o !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: rst_n_o=%b expected %b", req, what, rst_n_o, exp);
        end
    endtask

    task automatic run(input logic [7:0] code, input int edges);
        lvl_code = code;
        for (int k = 0; k < edges; k++) @(negedge clk);
    endtask

    initial begin
        srst       = 1'b1;
        lvl_code   = 8'd0;
        trip_lvl   = 8'd100;
        hyst_band  = 8'd10;
        hold_ticks = 8'd5;
        qual_ticks = 6'd4;
        @(negedge clk);
        @(negedge clk);
        check(1'b0, 8, "output during clear"); // R8
        srst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].code, int'(VECS[i].edges));
            check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R8: clear while released
        lvl_code = 8'd130;
        srst = 1'b1;
        @(negedge clk);
        check(1'b0, 8, "clear while running");
        srst = 1'b0;
        run(8'd130, 5);
        check(1'b0, 8, "wait then hold after clear");
        run(8'd130, 1);
        check(1'b1, 2, "release after clear");

        // R2/R3 boundary: period 1 and qual 1
        hold_ticks = 8'd1;
        qual_ticks = 6'd1;
        run(8'd130, 1);
        run(8'd95, 1);
        check(1'b0, 3, "single shallow sample trips at qual 1");
        run(8'd130, 1);
        check(1'b1, 2, "period of one tick");

        // R2: zero period acts as one
        hold_ticks = 8'd0;
        run(8'd95, 1);
        check(1'b0, 3, "trip before zero period");
        run(8'd130, 1);
        check(1'b1, 2, "zero period acts as one");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule